// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data-enable and the column and row of the current active pixel. Every timing quantity is programmed through a small write-only register port and stored as the wanted count minus one. A programmable clock-enable divider sets the pixel rate inside the single system clock domain, or can be bypassed so that every clock is a pixel.

Timing writes go to programmed copies. The raster uses separate working copies that are refreshed only at the wrap into a new frame, so a frame is never built from a mix of old and new values. The video enable is refreshed the same way. A frame interrupt can be raised at one of three raster positions. It sets a sticky pending flag that software clears by writing a one.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset all timing fields, the divider setting, the video enable, the interrupt settings and the pending flag are zero. With these values hsync_o, vsync_o, de_o, irq_o, pix_x_o and pix_y_o are low and pix_ce_o is high.
- R2: Each line is made of four regions in this order: sync, back porch, active, front porch. Their lengths in pixel ticks are the fields plus one. Register 1 holds the horizontal fields: sync width in bits [7:0], back porch in [15:8], front porch in [23:16]. hsync_o is high during the sync region of every line.
- R3: Each frame is made of lines in the same four-region order. Register 2 holds the vertical sync, back porch and front porch widths in lines, in the same bit positions as register 1. vsync_o is high for every pixel of the sync lines.
- R4: de_o is high only where an active column meets an active line. Register 3 holds the active width minus one in bits [15:0] and the active height minus one in bits [31:16]. While de_o is high, pix_x_o and pix_y_o give the zero-based position inside the active area. Otherwise both are zero.
- R5: Register 0 bit 1 set makes pix_ce_o pulse once every (bits [15:8] + 1) clocks. Bit 1 clear gives a pixel tick on every clock. A change of the divider takes effect at once.
- R6: The frame period is (hsync + hbp + xres + hfp) × (vsync + vbp + yres + vfp) pixel ticks.
- R7: Writes to registers 1, 2 and 3 do not affect the frame in progress. They apply from the first pixel of the next frame.
- R8: Register 0 bit 0 is the video enable. While its working copy is clear, hsync_o, vsync_o and de_o are low. A change of the bit applies only at the next frame start.
- R9: Register 4 bit 1 enables the frame event. Register 4 bits [3:2] select the event position: 0 is the first pixel of the frame, 1 is the first active pixel, 2 is the first front-porch column of the first front-porch line, and 3 selects no event. The pending flag is set on the clock after the pixel tick at the selected position.
- R10: irq_o is the pending flag ANDed with the global enable in register 4 bit 0. A pending flag set while that bit is clear appears on irq_o once the bit is set.
- R11: Writing register 5 with bit 0 set clears the pending flag. Writing it with bit 0 clear leaves the flag unchanged.
- R12: If a clear write and a new event fall in the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index 0 to 5 |
| reg_wdata_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| pix_x_o | output | 16 | Active column index |
| pix_y_o | output | 16 | Active row index |
| pix_ce_o | output | 1 | Pixel clock enable |
| irq_o | output | 1 | Frame interrupt request |

## Verification
The risky overlap is a software clear of the pending flag in the same clock as a new frame event. The bench's reference model predicts the pixel tick at which the selected event position is reached, and issues the clear write for exactly that edge. The result is judged by irq_o being still high afterwards. A second overlap is a timing write landing mid-frame next to the frame wrap. It is provoked by writing just after a vsync rise and measuring the sync pulse widths of the old and the new frame.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int SYNC_W = 8;
  localparam int SIZE_W = 16;
  localparam int DIV_W  = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int POS_W  = SIZE_W + 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_HTIME   = 3'd1,
    A_VTIME   = 3'd2,
    A_SIZE    = 3'd3,
    A_IRQCFG  = 3'd4,
    A_IRQSTAT = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    SEL_FRAME  = 2'd0,
    SEL_ACTIVE = 2'd1,
    SEL_PORCH  = 2'd2,
    SEL_NONE   = 2'd3
  } irq_sel_e;

  typedef struct packed {
    logic [SYNC_W-1:0] sync_m1;
    logic [SYNC_W-1:0] bp_m1;
    logic [SYNC_W-1:0] fp_m1;
    logic [SIZE_W-1:0] act_m1;
  } axis_cfg_t;
endpackage

// File: rtl/lcd_reg_bank.sv
module lcd_reg_bank
  import lcd_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              frame_load_i,
  output logic              div_en_o,
  output logic [DIV_W-1:0]  div_m1_o,
  output logic              gie_o,
  output logic              fie_o,
  output irq_sel_e          sel_o,
  output logic              clr_pend_o,
  output axis_cfg_t         h_cfg_o,
  output axis_cfg_t         v_cfg_o,
  output logic              ven_o
);
  localparam int LANE1 = 8;
  localparam int LANE2 = 16;

  logic      ven_q, ven_d, div_en_q, div_en_d, gie_q, gie_d, fie_q, fie_d;
  logic [DIV_W-1:0] div_m1_q, div_m1_d;
  logic [1:0] sel_q, sel_d;
  axis_cfg_t h_prog_q, h_prog_d, v_prog_q, v_prog_d;
  axis_cfg_t h_act_q, h_act_d, v_act_q, v_act_d;
  logic      ven_act_q, ven_act_d;

  always_comb begin
    ven_d    = ven_q;
    div_en_d = div_en_q;
    div_m1_d = div_m1_q;
    gie_d    = gie_q;
    fie_d    = fie_q;
    sel_d    = sel_q;
    h_prog_d = h_prog_q;
    v_prog_d = v_prog_q;
    if (we_i) begin
      case (reg_addr_e'(addr_i))
        A_CTRL: begin
          ven_d    = wdata_i[0];
          div_en_d = wdata_i[1];
          div_m1_d = wdata_i[LANE1 +: DIV_W];
        end
        A_HTIME: begin
          h_prog_d.sync_m1 = wdata_i[0 +: SYNC_W];
          h_prog_d.bp_m1   = wdata_i[LANE1 +: SYNC_W];
          h_prog_d.fp_m1   = wdata_i[LANE2 +: SYNC_W];
        end
        A_VTIME: begin
          v_prog_d.sync_m1 = wdata_i[0 +: SYNC_W];
          v_prog_d.bp_m1   = wdata_i[LANE1 +: SYNC_W];
          v_prog_d.fp_m1   = wdata_i[LANE2 +: SYNC_W];
        end
        A_SIZE: begin
          h_prog_d.act_m1 = wdata_i[0 +: SIZE_W];
          v_prog_d.act_m1 = wdata_i[LANE2 +: SIZE_W];
        end
        A_IRQCFG: begin
          gie_d = wdata_i[0];
          fie_d = wdata_i[1];
          sel_d = wdata_i[3:2];
        end
        default: ;
      endcase
    end
    h_act_d   = frame_load_i ? h_prog_q : h_act_q;
    v_act_d   = frame_load_i ? v_prog_q : v_act_q;
    ven_act_d = frame_load_i ? ven_q    : ven_act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ven_q     <= 1'b0;
      div_en_q  <= 1'b0;
      div_m1_q  <= '0;
      gie_q     <= 1'b0;
      fie_q     <= 1'b0;
      sel_q     <= '0;
      h_prog_q  <= '0;
      v_prog_q  <= '0;
      h_act_q   <= '0;
      v_act_q   <= '0;
      ven_act_q <= 1'b0;
    end else begin
      ven_q     <= ven_d;
      div_en_q  <= div_en_d;
      div_m1_q  <= div_m1_d;
      gie_q     <= gie_d;
      fie_q     <= fie_d;
      sel_q     <= sel_d;
      h_prog_q  <= h_prog_d;
      v_prog_q  <= v_prog_d;
      h_act_q   <= h_act_d;
      v_act_q   <= v_act_d;
      ven_act_q <= ven_act_d;
    end
  end

  assign div_en_o   = div_en_q;
  assign div_m1_o   = div_m1_q;
  assign gie_o      = gie_q;
  assign fie_o      = fie_q;
  assign sel_o      = irq_sel_e'(sel_q);
  assign clr_pend_o = we_i && (reg_addr_e'(addr_i) == A_IRQSTAT) && wdata_i[0];
  assign h_cfg_o    = h_act_q;
  assign v_cfg_o    = v_act_q;
  assign ven_o      = ven_act_q;

  // R7 / R8: working copies move only at the frame wrap
  p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_load_i |=> ($stable(h_act_q) && $stable(v_act_q) && $stable(ven_act_q)));
endmodule

// File: rtl/lcd_pix_div.sv
module lcd_pix_div
  import lcd_sync_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_en_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = !div_en_i || (cnt_q >= div_m1_i);

  always_comb begin
    if (!div_en_i)   cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5: in divided mode two ticks are never adjacent unless the ratio is 1
  p_div_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_en_i && tick_o && (div_m1_i != '0)) |=> (!tick_o || !div_en_i || (div_m1_i == '0)));
endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr
  import lcd_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  axis_cfg_t         cfg_i,
  output logic              last_o,
  output logic              at_start_o,
  output logic              at_act_o,
  output logic              at_fp_o,
  output logic              in_sync_o,
  output logic              in_active_o,
  output logic [SIZE_W-1:0] act_pos_o
);
  localparam int W = POS_W;

  logic [W-1:0] pos_q, pos_d;
  logic [W-1:0] sync_len, act_beg, act_end, total;

  assign sync_len = W'(cfg_i.sync_m1) + W'(1);
  assign act_beg  = sync_len + W'(cfg_i.bp_m1) + W'(1);
  assign act_end  = act_beg + W'(cfg_i.act_m1) + W'(1);
  assign total    = act_end + W'(cfg_i.fp_m1) + W'(1);

  assign last_o      = (pos_q == total - W'(1));
  assign at_start_o  = (pos_q == '0);
  assign at_act_o    = (pos_q == act_beg);
  assign at_fp_o     = (pos_q == act_end);
  assign in_sync_o   = (pos_q < sync_len);
  assign in_active_o = (pos_q >= act_beg) && (pos_q < act_end);
  assign act_pos_o   = in_active_o ? SIZE_W'(pos_q - act_beg) : '0;

  always_comb begin
    pos_d = pos_q;
    if (step_i) pos_d = last_o ? '0 : pos_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  // R2 / R3: position only moves on a step, and a step at the end wraps to zero
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o) |=> (pos_q == '0));
endmodule

// File: rtl/lcd_frame_irq.sv
module lcd_frame_irq
  import lcd_sync_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     ev_frame_i,
  input  logic     ev_active_i,
  input  logic     ev_porch_i,
  input  irq_sel_e sel_i,
  input  logic     fie_i,
  input  logic     gie_i,
  input  logic     clr_i,
  output logic     irq_o
);
  logic pend_q, pend_d, hit, set;

  always_comb begin
    case (sel_i)
      SEL_FRAME:  hit = ev_frame_i;
      SEL_ACTIVE: hit = ev_active_i;
      SEL_PORCH:  hit = ev_porch_i;
      default:    hit = 1'b0;
    endcase
  end

  assign set = tick_i && fie_i && hit;

  always_comb begin
    if (set)        pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign irq_o = pend_q && gie_i;

  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> pend_q);
  p_w1c_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !pend_q);
  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !set) |=> !pend_q);
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [SIZE_W-1:0] pix_x_o,
  output logic [SIZE_W-1:0] pix_y_o,
  output logic              pix_ce_o,
  output logic              irq_o
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             div_en, gie, fie, clr_pend, ven, tick, frame_load;
  logic [DIV_W-1:0] div_m1;
  irq_sel_e         sel;
  axis_cfg_t        h_cfg, v_cfg;

  logic h_last, h_start, h_act, h_fp, h_sync, h_in;
  logic v_last, v_start, v_act, v_fp, v_sync, v_in;
  logic [SIZE_W-1:0] h_pos, v_pos;

  lcd_reg_bank u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_q),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .frame_load_i (frame_load),
    .div_en_o     (div_en),
    .div_m1_o     (div_m1),
    .gie_o        (gie),
    .fie_o        (fie),
    .sel_o        (sel),
    .clr_pend_o   (clr_pend),
    .h_cfg_o      (h_cfg),
    .v_cfg_o      (v_cfg),
    .ven_o        (ven)
  );

  lcd_pix_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .div_en_i (div_en),
    .div_m1_i (div_m1),
    .tick_o   (tick)
  );

  lcd_axis_ctr u_hctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .step_i      (tick),
    .cfg_i       (h_cfg),
    .last_o      (h_last),
    .at_start_o  (h_start),
    .at_act_o    (h_act),
    .at_fp_o     (h_fp),
    .in_sync_o   (h_sync),
    .in_active_o (h_in),
    .act_pos_o   (h_pos)
  );

  lcd_axis_ctr u_vctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .step_i      (tick && h_last),
    .cfg_i       (v_cfg),
    .last_o      (v_last),
    .at_start_o  (v_start),
    .at_act_o    (v_act),
    .at_fp_o     (v_fp),
    .in_sync_o   (v_sync),
    .in_active_o (v_in),
    .act_pos_o   (v_pos)
  );

  assign frame_load = tick && h_last && v_last;

  lcd_frame_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .tick_i      (tick),
    .ev_frame_i  (h_start && v_start),
    .ev_active_i (h_act && v_act),
    .ev_porch_i  (h_fp && v_fp),
    .sel_i       (sel),
    .fie_i       (fie),
    .gie_i       (gie),
    .clr_i       (clr_pend),
    .irq_o       (irq_o)
  );

  assign hsync_o  = ven && h_sync;
  assign vsync_o  = ven && v_sync;
  assign de_o     = ven && h_in && v_in;
  assign pix_x_o  = de_o ? h_pos : '0;
  assign pix_y_o  = de_o ? v_pos : '0;
  assign pix_ce_o = tick;

  // R4: data enable never overlaps a sync pulse
  p_de_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    de_o |-> (!hsync_o && !vsync_o));
  // R8: with video off nothing toggles on the panel side
  p_video_off_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !ven |-> (!hsync_o && !vsync_o && !de_o));
endmodule

// File: tb/lcd_sync_gen_tb_top.sv
module lcd_sync_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic        hsync, vsync, de, pix_ce, irq;
  logic [15:0] px, py;

  always #10 clk = ~clk;

  lcd_sync_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_x_o(px), .pix_y_o(py),
    .pix_ce_o(pix_ce), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int p_ven, p_diven, p_divm1, p_gie, p_fie, p_sel;
  int p_hs, p_hb, p_hf, p_xr, p_vs, p_vb, p_vf, p_yr;
  int a_ven, a_hs, a_hb, a_hf, a_xr, a_vs, a_vb, a_vf, a_yr;
  int m_h, m_v, m_cnt, m_pend, m_rcnt;

  function automatic int htot(); return a_hs + a_hb + a_xr + a_hf + 4; endfunction
  function automatic int vtot(); return a_vs + a_vb + a_yr + a_vf + 4; endfunction
  function automatic int m_tick(); return (p_diven == 0 || m_cnt >= p_divm1) ? 1 : 0; endfunction
  function automatic int m_event();
    case (p_sel)
      0: return (m_h == 0 && m_v == 0) ? 1 : 0;
      1: return (m_h == a_hs + a_hb + 2 && m_v == a_vs + a_vb + 2) ? 1 : 0;
      2: return (m_h == a_hs + a_hb + a_xr + 3 && m_v == a_vs + a_vb + a_yr + 3) ? 1 : 0;
      default: return 0;
    endcase
  endfunction
  function automatic int m_next_set(); return (m_tick() && m_event() && p_fie) ? 1 : 0; endfunction
  function automatic int e_de();
    return (a_ven && m_h >= a_hs + a_hb + 2 && m_h < a_hs + a_hb + a_xr + 3 &&
            m_v >= a_vs + a_vb + 2 && m_v < a_vs + a_vb + a_yr + 3) ? 1 : 0;
  endfunction

  task automatic m_reset();
    {p_ven, p_diven, p_divm1, p_gie, p_fie, p_sel} = '0;
    {p_hs, p_hb, p_hf, p_xr, p_vs, p_vb, p_vf, p_yr} = '0;
    {a_ven, a_hs, a_hb, a_hf, a_xr, a_vs, a_vb, a_vf, a_yr} = '0;
    m_h = 0; m_v = 0; m_cnt = 0; m_pend = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset();
      m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      int t, hl, vl, setp, clrp;
      t = m_tick();
      hl = (m_h == htot() - 1);
      vl = (m_v == vtot() - 1);
      setp = m_next_set();
      clrp = (we && addr == 3'd5 && wdata[0]) ? 1 : 0;
      if (t) begin
        if (hl) begin m_h = 0; m_v = vl ? 0 : m_v + 1; end
        else m_h = m_h + 1;
      end
      if (t && hl && vl) begin
        a_ven = p_ven; a_hs = p_hs; a_hb = p_hb; a_hf = p_hf; a_xr = p_xr;
        a_vs = p_vs; a_vb = p_vb; a_vf = p_vf; a_yr = p_yr;
      end
      m_cnt = (p_diven == 0) ? 0 : (t ? 0 : m_cnt + 1);
      m_pend = setp ? 1 : (clrp ? 0 : m_pend);
      if (we) begin
        case (addr)
          3'd0: begin p_ven = wdata[0]; p_diven = wdata[1]; p_divm1 = wdata[15:8]; end
          3'd1: begin p_hs = wdata[7:0]; p_hb = wdata[15:8]; p_hf = wdata[23:16]; end
          3'd2: begin p_vs = wdata[7:0]; p_vb = wdata[15:8]; p_vf = wdata[23:16]; end
          3'd3: begin p_xr = wdata[15:0]; p_yr = wdata[31:16]; end
          3'd4: begin p_gie = wdata[0]; p_fie = wdata[1]; p_sel = wdata[3:2]; end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      int ed;
      ed = e_de();
      check("R2", "hsync", hsync, (a_ven && m_h < a_hs + 1) ? 1 : 0);
      check("R3", "vsync", vsync, (a_ven && m_v < a_vs + 1) ? 1 : 0);
      check("R4", "de", de, ed);
      check("R4", "pix_x", px, ed ? m_h - (a_hs + a_hb + 2) : 0);
      check("R4", "pix_y", py, ed ? m_v - (a_vs + a_vb + 2) : 0);
      check("R5", "pix_ce", pix_ce, m_tick());
      check("R10", "irq", irq, (m_pend && p_gie) ? 1 : 0);
    end
  end

  // ---------------- measurement monitors ----------------
  int cyc = 0, vs_rises = 0, last_rise = 0, period = 0;
  int hs_run = 0, hs_falls = 0, last_hs = 0;
  bit vs_prev = 0, hs_prev = 0;
  always @(negedge clk) begin
    cyc++;
    if (vsync && !vs_prev) begin
      period = cyc - last_rise; last_rise = cyc; vs_rises++;
    end
    if (hsync) hs_run++;
    if (!hsync && hs_prev) begin last_hs = hs_run; hs_run = 0; hs_falls++; end
    vs_prev = vsync; hs_prev = hsync;
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic wr(int a, logic [31:0] d);
    we = 1'b1; addr = 3'(a); wdata = d; step(); we = 1'b0; wdata = '0;
  endtask
  task automatic wait_vs();
    int c = vs_rises;
    while (vs_rises == c) step();
  endtask
  task automatic wait_hs_fall();
    int c = hs_falls;
    while (hs_falls == c) step();
  endtask
  function automatic logic [31:0] tim(int s, int b, int f);
    return 32'(s) | (32'(b) << 8) | (32'(f) << 16);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired before the test sequence ended");
    finish_run();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (5) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1 reset state
    check("R1", "hsync", hsync, 0); check("R1", "vsync", vsync, 0);
    check("R1", "de", de, 0);       check("R1", "irq", irq, 0);
    check("R1", "pix_ce", pix_ce, 1);
    check("R1", "pix_xy", px | py, 0);
    cmp_en = 1;

    // frame: h 2+3+8+2 = 15, v 1+2+4+1 = 8 -> 120 ticks
    wr(1, tim(1, 2, 1));
    wr(2, tim(0, 1, 0));
    wr(3, 32'h0003_0007);
    wr(4, 32'h3);                 // gie, fie, select frame start
    wr(0, 32'h1);                 // video on, bypass divider
    wait_vs(); wait_vs();
    check("R6", "frame period bypass", period, 120);
    cnt = 0;
    for (int i = 0; i < 120; i++) begin step(); cnt += de; end
    check("R4", "de per frame", cnt, 32);

    // R11 write-one-to-clear
    check("R9", "pending at frame start", irq, 1);
    wr(5, 32'h0); check("R11", "zero write ignored", irq, 1);
    wr(5, 32'h1); check("R11", "cleared", irq, 0);

    // R12 clear and set in the same clock
    while (!m_next_set()) step();
    wr(5, 32'h1);
    check("R12", "set wins over clear", irq, 1);
    wr(5, 32'h1);

    // R7 mid-frame timing write
    wait_vs();
    wr(1, tim(3, 2, 1));          // line becomes 17
    wait_hs_fall();
    check("R7", "old hsync width", last_hs, 2);
    wait_vs(); wait_hs_fall();
    check("R7", "new hsync width", last_hs, 4);
    wait_vs();
    check("R6", "frame period new", period, 136);

    // R5 divider
    wr(0, 32'h0000_0203);
    wait_vs(); wait_vs();
    check("R5", "frame period divided", period, 408);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(); cnt += pix_ce; end
    check("R5", "ticks in 30 clocks", cnt, 10);
    wr(0, 32'h1);
    wait_vs(); wait_vs();

    // R10 global gate
    wr(4, 32'h2); wr(5, 32'h1);
    wait_vs(); step(); step();
    check("R10", "masked irq", irq, 0);
    wr(4, 32'h3);
    check("R10", "stored pending shows", irq, 1);
    wr(5, 32'h1);

    // R9 enables and selects
    wr(4, 32'h1); wr(5, 32'h1);
    wait_vs(); step(); step();
    check("R9", "frame enable off", irq, 0);
    wr(4, 32'hF);
    wait_vs(); wait_vs();
    check("R9", "select none", irq, 0);
    wr(4, 32'h7);
    wait_vs(); wr(5, 32'h1);
    check("R9", "active select before de", irq, 0);
    while (!de) step();
    step();
    check("R9", "active select after first pixel", irq, 1);
    wr(4, 32'hB); wait_vs(); wr(5, 32'h1);
    wait_vs();
    check("R9", "porch select", irq, 1);
    wr(5, 32'h1);

    // R8 video enable applies at frame start
    wait_vs();
    wr(0, 32'h0);
    cnt = 0;
    for (int i = 0; i < 134; i++) begin step(); cnt += de; end
    check("R8", "de continues to frame end", cnt, 32);
    cnt = 0;
    for (int i = 0; i < 136; i++) begin step(); cnt += de + hsync + vsync; end
    check("R8", "outputs quiet when off", cnt, 0);

    finish_run();
  end
endmodule